// File: doc/BRIEF.md
# Two-Channel Serial Audio Receiver with No-Signal Flag

The block takes a stereo serial audio stream made of a bit clock, a frame clock and a data line. All three come from outside and are sampled by a faster system clock. It rebuilds one 16-bit two's-complement word per channel per frame. Each word is handed out in a per-channel output register, together with a one-cycle strobe and a tag that says which channel has just finished. The half-frame may carry anywhere from 16 to 32 bit-clock periods. Only the final 16 rising bit-clock edges before the frame-clock edge that closes a half-frame form the word, so any bit-clock rate from 32 to 64 times the frame rate is accepted without configuration.

A no-signal flag is provided alongside the samples. It is high out of reset and stays high until the first one bit is seen on the data line. It rises again once the data line has delivered nothing but zeros for a programmable number of frames, 16384 by default. A single one bit drops the flag and restarts the count.

After reset the receiver delivers nothing until it has observed a rising frame-clock edge. This keeps a partial first half-frame from being presented as a sample.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset, `left_o` and `right_o` are zero, `smp_valid_o` is low and `no_signal_o` is high.
- R2: A delivered word is the value of the last 16 data bits sampled on rising bit-clock edges before the closing frame-clock edge. The first of those 16 bits is the most significant. Any bits earlier in the half-frame have no effect, for half-frames of 16 to 32 bit periods.
- R3: Frame clock high is the left half-frame and low is the right half-frame. A falling frame-clock edge loads `left_o` and sets `smp_is_left_o` to 1. A rising edge loads `right_o` and sets `smp_is_left_o` to 0.
- R4: Each frame-clock edge after lock produces exactly one `smp_valid_o` pulse, one system-clock cycle wide. The output register of the other channel keeps its value across that pulse.
- R5: No strobe is produced before the first rising frame-clock edge after reset, and none is produced on that rising edge itself.
- R6: `no_signal_o` stays high from reset while only zero bits are sampled. It goes low on the first one bit sampled on a rising bit-clock edge.
- R7: `no_signal_o` goes high once ZERO_FRAMES rising frame-clock edges have passed without any one bit sampled. It stays high while zeros continue, and the run counter saturates.
- R8: Any one bit sampled on the data line clears `no_signal_o` and restarts the zero-run count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrck_i | input | 1 | Frame clock; high for left, low for right |
| sdata_i | input | 1 | Serial data, MSB first, rear-packed |
| left_o | output | 16 | Most recent left-channel word |
| right_o | output | 16 | Most recent right-channel word |
| smp_valid_o | output | 1 | One-cycle strobe when a word has just been loaded |
| smp_is_left_o | output | 1 | 1 when the last loaded word is left, 0 when right |
| no_signal_o | output | 1 | High while no one bit has arrived for ZERO_FRAMES frames, or since reset |

## Verification
The hardest condition to reach is the zero-run threshold. Its default length is far beyond any short run, so the bench elaborates the block with a small ZERO_FRAMES. It then follows a frame whose last right-channel bit is forced to one with a run of all-zero frames, including the padding bits, and checks the flag in the middle of each left half. The check must show the flag low for exactly ZERO_FRAMES-1 edges and high from the next one on. Repeating this after a lone one bit in a later frame proves the count restarts. The lock rule is reached by holding the frame clock high through reset and driving a falling edge before any rising one. Rear-packing is exercised with random and extreme amounts of leading padding.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  typedef struct packed {
    logic bit_rise;
    logic bit_val;
    logic frame_rise;
    logic frame_fall;
  } rx_events_t;

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/aud_rx_edges.sv
module aud_rx_edges
  import aud_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_s,
  input  logic       lrck_s,
  input  logic       din_s,
  output rx_events_t ev,
  output logic       locked,
  output logic       lrck_lvl
);

  // wait until the synchroniser chain and the history flop hold real input
  localparam int SETTLE = STAGES + 1;
  localparam int SW     = $clog2(SETTLE + 1);

  logic [SW-1:0] settle;
  logic          ready;
  logic          bclk_q;
  logic          lrck_q;

  assign ready = (settle == SW'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      locked <= 1'b0;
    end else begin
      bclk_q <= bclk_s;
      lrck_q <= lrck_s;
      if (!ready) settle <= settle + 1'b1;
      if (ev.frame_rise) locked <= 1'b1;
    end
  end

  always_comb begin
    ev.bit_rise   = ready & bclk_s & ~bclk_q;
    ev.bit_val    = din_s;
    ev.frame_rise = ready & lrck_s & ~lrck_q;
    ev.frame_fall = ready & ~lrck_s & lrck_q;
  end

  assign lrck_lvl = lrck_s;

  AST_LOCK_BY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ev.frame_rise)); // R5

endmodule

// File: rtl/aud_rx_capture.sv
module aud_rx_capture
  import aud_rx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rx_events_t   ev,
  input  logic         locked,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o,
  output chan_e        chan_o
);

  logic [W-1:0] sr;

  // MSB-first: older bits move toward the top, so the final W bits remain
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  logic frame_edge;
  assign frame_edge = locked & (ev.frame_rise | ev.frame_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
      chan_o  <= CH_RIGHT;
    end else begin
      valid_o <= frame_edge;
      if (ev.bit_rise) sr <= shift_in(sr, ev.bit_val);
      if (frame_edge) begin
        if (ev.frame_fall) begin
          left_o <= sr;
          chan_o <= CH_LEFT;
        end else begin
          right_o <= sr;
          chan_o  <= CH_RIGHT;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R4
  AST_RIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && chan_o == CH_LEFT) |-> $stable(right_o)); // R4
  AST_LEFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && chan_o == CH_RIGHT) |-> $stable(left_o)); // R4

endmodule

// File: rtl/aud_rx_zero.sv
module aud_rx_zero #(
  parameter int LIMIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_rise,
  input  logic bit_val,
  input  logic frame_rise,
  output logic no_signal
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic          one_seen;

  function automatic logic [CW-1:0] run_step(input logic [CW-1:0] c);
    return (c < LIM) ? c + 1'b1 : c;
  endfunction

  assign one_seen = bit_rise & bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      no_signal <= 1'b1;
    end else if (one_seen) begin
      cnt       <= '0;
      no_signal <= 1'b0;
    end else if (frame_rise) begin
      cnt <= run_step(cnt);
      if (run_step(cnt) == LIM) no_signal <= 1'b1;
    end
  end

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    one_seen |=> !no_signal); // R8
  AST_FLAG_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_signal) |-> $past(frame_rise)); // R7

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ZERO_FRAMES = 16384
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                smp_valid_o,
  output logic                smp_is_left_o,
  output logic                no_signal_o
);

  logic [2:0] raw_in;
  logic [2:0] syn;
  rx_events_t ev;
  logic       locked;
  logic       lrck_lvl;
  chan_e      chan;

  assign raw_in = {sdata_i, lrck_i, bclk_i};

  aud_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  aud_rx_edges #(.STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(syn[0]), .lrck_s(syn[1]), .din_s(syn[2]),
    .ev(ev), .locked(locked), .lrck_lvl(lrck_lvl)
  );

  aud_rx_capture #(.W(SAMPLE_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .ev(ev), .locked(locked),
    .left_o(left_o), .right_o(right_o), .valid_o(smp_valid_o), .chan_o(chan)
  );

  aud_rx_zero #(.LIMIT(ZERO_FRAMES)) u_zero (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(ev.bit_rise), .bit_val(ev.bit_val), .frame_rise(ev.frame_rise),
    .no_signal(no_signal_o)
  );

  assign smp_is_left_o = (chan == CH_LEFT);

  AST_NO_OUT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(locked) |-> !smp_valid_o); // R5
  AST_TAG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> (smp_is_left_o != lrck_lvl)); // R3

endmodule

// File: tb/aud_serial_rx_bench.sv
`timescale 1ns/1ps
module aud_serial_rx_bench;

  localparam int W  = 16;
  localparam int ZF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, lrck = 1'b1, sdata = 1'b0;
  logic [W-1:0] left_o, right_o;
  logic smp_valid_o, smp_is_left_o, no_signal_o;

  always #2 clk = ~clk;

  aud_serial_rx #(.SAMPLE_W(W), .SYNC_STAGES(2), .ZERO_FRAMES(ZF)) u_aud_serial_rx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .smp_valid_o(smp_valid_o),
    .smp_is_left_o(smp_is_left_o), .no_signal_o(no_signal_o)
  );

  int checks = 0, failures = 0;
  logic [W-1:0] exp_l [64];
  logic [W-1:0] exp_r [64];
  int fi = 0, nl = 0, nr = 0;
  bit bench_locked = 0;
  bit prev_valid = 0;
  logic [W-1:0] seen_l = '0, seen_r = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected word from the padding/word split: only the final W bits count
  function automatic logic [W-1:0] rear_word(input logic [W-1:0] word);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[W-1-i] = word[W-1-i];
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && smp_valid_o) begin
      chk(!prev_valid, "R4", "strobe wider than one cycle", 1, 0);
      chk(bench_locked, "R5", "strobe before lock", 1, 0);
      if (smp_is_left_o) begin
        chk(left_o == exp_l[nl], "R2", "left word", left_o, exp_l[nl]);
        chk(right_o == seen_r, "R4", "right held on left strobe", right_o, seen_r);
        seen_l = left_o;
        nl++;
      end else begin
        chk(right_o == exp_r[nr], "R2", "right word", right_o, exp_r[nr]);
        chk(left_o == seen_l, "R4", "left held on right strobe", left_o, seen_l);
        seen_r = right_o;
        nr++;
      end
    end
    prev_valid = rst_n && smp_valid_o;
  end

  task automatic drive_bit(input logic b, input bit first, input logic lvl);
    bclk  = 1'b0;
    sdata = b;
    if (first) lrck = lvl;
    #16;
    bclk = 1'b1;
    #16;
  endtask

  task automatic drive_half(input logic lvl, input logic [W-1:0] word,
                            input int pad, input bit pad_ones);
    for (int i = 0; i < pad; i++)
      drive_bit(pad_ones ? 1'($urandom_range(1, 0)) : 1'b0, i == 0, lvl);
    for (int i = W - 1; i >= 0; i--)
      drive_bit(word[i], (pad == 0) && (i == W - 1), lvl);
  endtask

  task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r,
                       input int padl, input int padr, input bit pad_ones);
    exp_l[fi] = rear_word(l);
    exp_r[fi] = rear_word(r);
    fi++;
    bench_locked = 1;
    drive_half(1'b1, l, padl, pad_ones);
    drive_half(1'b0, r, padr, pad_ones);
  endtask

  initial begin
    #(4 * 190000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] l, r;
    void'($urandom(32'd2024));
    #21;
    rst_n = 1'b1;
    #40;
    @(negedge clk);
    chk(left_o == 0, "R1", "left after reset", left_o, 0);
    chk(right_o == 0, "R1", "right after reset", right_o, 0);
    chk(smp_valid_o == 0, "R1", "strobe after reset", smp_valid_o, 0);
    chk(no_signal_o == 1, "R1", "flag after reset", no_signal_o, 1);

    // pre-lock: left half (no edge), falling edge, right half, all zeros
    drive_half(1'b1, 16'h0000, 4, 0);
    drive_half(1'b0, 16'h0000, 4, 0);
    @(negedge clk);
    chk(nl == 0 && nr == 0, "R5", "words before lock", nl + nr, 0);
    chk(no_signal_o == 1, "R6", "flag with only zeros", no_signal_o, 1);

    // directed words and padding extremes
    exp_l[fi] = 16'h8000; exp_r[fi] = 16'h7FFF; fi++;
    bench_locked = 1;
    drive_half(1'b1, 16'h8000, 0, 1);
    @(negedge clk);
    chk(no_signal_o == 0, "R6", "flag drops on first one", no_signal_o, 0);
    drive_half(1'b0, 16'h7FFF, 16, 1);
    frame(16'hFFFF, 16'h0001, 16, 0, 1);
    frame(16'h5A5A, 16'hA5A5, 16, 16, 1);

    for (int k = 0; k < 20; k++) begin
      l = 16'($urandom);
      r = 16'($urandom);
      if (k == 19) r = r | 16'h0001;
      frame(l, r, $urandom_range(16, 0), $urandom_range(16, 0), 1);
    end

    // zero run reaching the threshold, then saturation
    for (int j = 0; j < ZF + 4; j++) begin
      exp_l[fi] = 0; exp_r[fi] = 0; fi++;
      drive_half(1'b1, 16'h0000, $urandom_range(16, 0), 0);
      chk(no_signal_o == (j >= ZF - 1), (j >= ZF - 1) ? "R7" : "R7",
          "flag during zero run", no_signal_o, (j >= ZF - 1));
      drive_half(1'b0, 16'h0000, $urandom_range(16, 0), 0);
    end

    // a lone one bit clears the flag and restarts the count
    exp_l[fi] = 16'h0400; exp_r[fi] = 0; fi++;
    drive_half(1'b1, 16'h0400, 3, 0);
    @(negedge clk);
    chk(no_signal_o == 0, "R8", "flag cleared by one bit", no_signal_o, 0);
    drive_half(1'b0, 16'h0000, 3, 0);
    for (int j = 0; j < ZF; j++) begin
      exp_l[fi] = 0; exp_r[fi] = 0; fi++;
      drive_half(1'b1, 16'h0000, 5, 0);
      chk(no_signal_o == (j >= ZF - 1), "R8", "count restarted", no_signal_o,
          (j >= ZF - 1));
      drive_half(1'b0, 16'h0000, 5, 0);
    end

    // closing rising edge delivers the final right word
    bclk = 1'b0;
    lrck = 1'b1;
    #200;
    @(negedge clk);
    chk(nl == fi, "R3", "left words delivered", nl, fi);
    chk(nr == fi, "R3", "right words delivered", nr, fi);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule